// File: doc/BRIEF.md
# Interrupt In-Service and End-of-Interrupt Tracker

This block keeps the per-source pending and in-service flags for a small, fixed-priority interrupt controller. Each source has its own request line. A rising edge on that line latches a pending flag. A single acknowledge strobe moves the current winner from pending into service. Source `i` has priority level `i`, and level 0 is the highest. Source `i` reports the type code `TYPE_BASE + i`.

Software reaches the block through a small register port. Address 0 is a read-only poll word. Its top bit says whether a request is eligible for service, and its low five bits give the type code of the best eligible request. Address 1 is a write-only end-of-interrupt port that clears in-service flags. The `slave_mode_i` pin selects how that port decodes its data. In master mode a write is either non-specific or specific by type code. In slave mode a write clears by a three-bit priority level.

Top module: `irq_svc_tracker`

## Requirements
- R1: After reset, no source is pending or in service. A poll read returns 0x0000 and `inserv_o` is all zero.
- R2: A poll read (address 0) returns bit 15 = 1 when at least one request is eligible. Bits 4..0 then hold `TYPE_BASE + i`, where `i` is the lowest eligible level. Bits 14..5 always read 0. With no eligible request the whole word reads 0x0000.
- R3: A read of the end-of-interrupt address (1) returns 0x0000. A write to the poll address changes nothing.
- R4: A 0-to-1 transition on `req_i[i]` sets the pending flag of source `i`. The flag stays set until that source is acknowledged, even if the request line drops.
- R5: A pending request at level `i` is eligible only if `i` is lower than every level currently in service.
- R6: `ack_i` sets the in-service flag of the lowest eligible level and clears that source's pending flag in the same clock. With no eligible request, `ack_i` changes nothing.
- R7: In master mode, an end-of-interrupt write with bit 15 = 1 clears the lowest-level in-service flag. With nothing in service it changes nothing.
- R8: In master mode, an end-of-interrupt write with bit 15 = 0 clears only the in-service flag of the source whose type equals bits 4..0. A type that matches no source changes nothing.
- R9: In slave mode, an end-of-interrupt write clears the in-service flag at the level in bits 2..0. Bits 15..3 are ignored, including bit 15.
- R10: When an end-of-interrupt write and `ack_i` occur in the same clock, the clear is applied first. The acknowledge then picks its winner from the cleared in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slave_mode_i | input | 1 | 1 selects the level-based end-of-interrupt format |
| req_i | input | N_SRC | Per-source request lines, edge-latched |
| ack_i | input | 1 | Moves the current winner into service |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = poll word, 1 = end-of-interrupt port |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| inserv_o | output | N_SRC | In-service flags, bit `i` = level `i` |

## Verification
A wrong in-service flag shows up in two places. It shows on `inserv_o` one clock after the acknowledge or clear that produced it. It also shows in the next poll read, as a masked or unmasked type code, because eligibility depends on the in-service state. A lost or stuck pending flag shows at the next poll read, or when a later acknowledge moves a different source into service. The bench replays every clock against a model built from the requirements. It mixes directed cases for same-cycle clear-and-acknowledge, clears that match nothing, and slave-format writes with high bits set.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int unsigned DATA_W       = 16;
  localparam int unsigned TYPE_W       = 5;
  localparam int unsigned LVL_W        = 3;
  localparam int unsigned POLL_VLD_BIT = 15;
  localparam int unsigned EOI_NSPEC    = 15;
  localparam logic        ADDR_POLL    = 1'b0;
  localparam logic        ADDR_EOI     = 1'b1;

  typedef enum logic {
    EOI_FMT_MASTER = 1'b0,
    EOI_FMT_SLAVE  = 1'b1
  } eoi_fmt_e;
endpackage

// File: rtl/prio_pick.sv
// Fixed-priority pick, bit 0 highest.
module prio_pick #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic [N-1:0]     onehot_o,
  output logic [N-1:0]     higher_o,  // levels strictly above the winner; all ones when vec_i == 0
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  assign onehot_o = vec_i & (~vec_i + N'(1));
  assign higher_o = onehot_o - N'(1);
  assign any_o    = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/eoi_decode.sv
// Turns an end-of-interrupt write into a clear mask.
module eoi_decode
  import irq_trk_pkg::*;
#(
  parameter int unsigned N         = 8,
  parameter int unsigned TYPE_BASE = 8
) (
  input  logic              wr_stb_i,
  input  eoi_fmt_e          fmt_i,
  input  logic              nspec_i,
  input  logic [TYPE_W-1:0] code_i,
  input  logic [N-1:0]      ins_top_i,
  output logic [N-1:0]      clr_o
);
  logic [N-1:0] spec_hit;
  logic [N-1:0] lvl_hit;

  for (genvar i = 0; i < N; i++) begin : g_hit
    localparam logic [TYPE_W-1:0] SRC_TYPE = TYPE_W'(TYPE_BASE + i);
    assign spec_hit[i] = (code_i == SRC_TYPE);
    assign lvl_hit[i]  = (code_i[LVL_W-1:0] == LVL_W'(i));
  end

  always_comb begin
    clr_o = '0;
    if (wr_stb_i) begin
      unique case (fmt_i)
        EOI_FMT_SLAVE:  clr_o = lvl_hit;
        EOI_FMT_MASTER: clr_o = nspec_i ? ins_top_i : spec_hit;
        default:        clr_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker
  import irq_trk_pkg::*;
#(
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned TYPE_BASE = 8,
  localparam int unsigned IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_mode_i,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              ack_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_SRC-1:0]  inserv_o
);
  logic [N_SRC-1:0] req_q, pend_q, ins_q;
  logic [N_SRC-1:0] req_edge, clr, ins_mid, grant;
  logic [N_SRC-1:0] ins_top, ins_higher, mid_higher;
  logic [N_SRC-1:0] elig_now, elig_mid, win_oh;
  logic [N_SRC-1:0] mid_oh_unused, poll_oh_unused, poll_hi_unused, win_hi_unused;
  logic [IDX_W-1:0] poll_idx, ins_idx_unused, mid_idx_unused, win_idx_unused;
  logic             poll_any, ins_any_unused, mid_any_unused, win_any_unused;
  logic             eoi_stb, poll_rd, eoi_rd;
  logic [DATA_W-1:0] poll_word;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-2:TYPE_W];

  assign req_edge = req_i & ~req_q;
  assign eoi_stb  = sel_i & wr_i & (addr_i == ADDR_EOI);
  assign poll_rd  = sel_i & ~wr_i & (addr_i == ADDR_POLL);
  assign eoi_rd   = sel_i & ~wr_i & (addr_i == ADDR_EOI);

  prio_pick #(.N(N_SRC)) u_ins_now (
    .vec_i(ins_q), .onehot_o(ins_top), .higher_o(ins_higher),
    .idx_o(ins_idx_unused), .any_o(ins_any_unused)
  );

  eoi_decode #(.N(N_SRC), .TYPE_BASE(TYPE_BASE)) u_eoi (
    .wr_stb_i (eoi_stb),
    .fmt_i    (slave_mode_i ? EOI_FMT_SLAVE : EOI_FMT_MASTER),
    .nspec_i  (wdata_i[EOI_NSPEC]),
    .code_i   (wdata_i[TYPE_W-1:0]),
    .ins_top_i(ins_top),
    .clr_o    (clr)
  );

  // clear first, then the acknowledge sees the reduced in-service set
  assign ins_mid = ins_q & ~clr;

  prio_pick #(.N(N_SRC)) u_ins_mid (
    .vec_i(ins_mid), .onehot_o(mid_oh_unused), .higher_o(mid_higher),
    .idx_o(mid_idx_unused), .any_o(mid_any_unused)
  );

  assign elig_now = pend_q & ins_higher;
  assign elig_mid = pend_q & mid_higher;

  prio_pick #(.N(N_SRC)) u_poll (
    .vec_i(elig_now), .onehot_o(poll_oh_unused), .higher_o(poll_hi_unused),
    .idx_o(poll_idx), .any_o(poll_any)
  );

  prio_pick #(.N(N_SRC)) u_win (
    .vec_i(elig_mid), .onehot_o(win_oh), .higher_o(win_hi_unused),
    .idx_o(win_idx_unused), .any_o(win_any_unused)
  );

  assign grant = ack_i ? win_oh : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[i]  <= 1'b0;
        pend_q[i] <= 1'b0;
        ins_q[i]  <= 1'b0;
      end else begin
        req_q[i]  <= req_i[i];
        pend_q[i] <= (pend_q[i] & ~grant[i]) | req_edge[i];
        ins_q[i]  <= ins_mid[i] | grant[i];
      end
    end
  end

  always_comb begin
    poll_word = '0;
    if (poll_any) begin
      poll_word[POLL_VLD_BIT]   = 1'b1;
      poll_word[TYPE_W-1:0]     = TYPE_W'(TYPE_BASE) + TYPE_W'(poll_idx);
    end
  end

  assign rdata_o  = poll_rd ? poll_word : '0;
  assign inserv_o = ins_q;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-2:TYPE_W] == '0);                                    // R2
  AST_POLL_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd && !rdata_o[POLL_VLD_BIT]) |-> rdata_o == '0);             // R2
  AST_EOI_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_rd |-> rdata_o == '0);                                          // R3
  AST_ONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr));                                                     // R7
  AST_NO_ACK_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> (ins_q & ~$past(ins_q)) == '0);                          // R6
  AST_SET_WAS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_q & ~$past(ins_q) & ~$past(pend_q)) == '0);                    // R6
  AST_SINGLE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ins_q & ~$past(ins_q)) <= 1);                            // R6
  AST_NO_EOI_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoi_stb |=> ($past(ins_q) & ~ins_q) == '0);                        // R8
endmodule

// File: tb/irq_svc_tracker_tb.sv
`timescale 1ns/1ps
module irq_svc_tracker_tb;
  localparam int N  = 8;
  localparam int TB = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic slave_mode = 1'b0, ack = 1'b0, sel = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [N-1:0] req = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [N-1:0] inserv;

  int checks = 0, errors = 0;
  logic [N-1:0] m_req = '0, m_pend = '0, m_ins = '0;

  always #10 clk = ~clk;

  irq_svc_tracker #(.N_SRC(N), .TYPE_BASE(TB)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .slave_mode_i(slave_mode), .req_i(req),
    .ack_i(ack), .sel_i(sel), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .inserv_o(inserv)
  );

  function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [N-1:0] above(input logic [N-1:0] ins);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) begin
      if (ins[i]) return m;
      m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [15:0] exp_poll(input logic [N-1:0] p, input logic [N-1:0] s);
    logic [N-1:0] e = p & above(s);
    for (int i = 0; i < N; i++) if (e[i]) return 16'h8000 | 16'(TB + i);
    return 16'h0000;
  endfunction

  function automatic logic [N-1:0] exp_clr(input logic slv, input logic [15:0] d, input logic [N-1:0] s);
    logic [N-1:0] c = '0;
    if (slv) begin
      for (int i = 0; i < N; i++) if (d[2:0] == 3'(i)) c[i] = 1'b1;
    end else if (d[15]) begin
      c = lowest(s);
    end else begin
      for (int i = 0; i < N; i++) if (d[4:0] == 5'(TB + i)) c[i] = 1'b1;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // entered at a negedge; returns at the next negedge
  task automatic cycle(input string tag, input logic [N-1:0] r, input logic a,
                       input logic s, input logic w, input logic ad, input logic [15:0] d);
    logic [N-1:0] clr, mid, win;
    req = r; ack = a; sel = s; wr = w; addr = ad; wdata = d;
    #2;
    if (s && !w) chk({tag, " rd"}, rdata, ad ? 16'h0000 : exp_poll(m_pend, m_ins));
    @(posedge clk);
    clr = (s && w && ad) ? exp_clr(slave_mode, d, m_ins) : '0;
    mid = m_ins & ~clr;
    win = a ? lowest(m_pend & above(mid)) : '0;
    m_ins  = mid | win;
    m_pend = (m_pend & ~win) | (r & ~m_req);
    m_req  = r;
    @(negedge clk);
    chk({tag, " ins"}, 16'(inserv), 16'(m_ins));
  endtask

  task automatic rd(input string tag, input logic [N-1:0] r);
    cycle(tag, r, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    sel = 1'b1; #2;
    chk("R1 poll after reset", rdata, 16'h0000);
    chk("R1 ins after reset", 16'(inserv), 16'h0000);
    sel = 1'b0;

    cycle("R4 edge src5", 8'h20, 0, 0, 0, 0, 16'h0);
    rd("R2 poll src5", 8'h20);
    chk("R2 poll type", rdata, 16'h800D);
    cycle("R6 ack src5", 8'h20, 1, 1, 0, 0, 16'h0);
    cycle("R4 edge src6", 8'h60, 0, 0, 0, 0, 16'h0);
    rd("R5 lower level masked", 8'h60);
    chk("R5 masked poll", rdata, 16'h0000);
    cycle("R4 edge src0", 8'h61, 0, 0, 0, 0, 16'h0);
    rd("R5 higher level visible", 8'h00);
    chk("R5 poll src0", rdata, 16'h8008);
    cycle("R10 eoi+ack", 8'h00, 1, 1, 1, 1, 16'h8000);
    chk("R10 src0 in service", 16'(inserv), 16'h0001);
    cycle("R8 nonmatching type", 8'h00, 0, 1, 1, 1, 16'h000E);
    cycle("R8 type out of range", 8'h00, 0, 1, 1, 1, 16'h001F);
    cycle("R3 poll write ignored", 8'h00, 0, 1, 1, 0, 16'hFFFF);
    cycle("R8 specific clear", 8'h00, 0, 1, 1, 1, 16'h0008);
    chk("R8 cleared", 16'(inserv), 16'h0000);
    cycle("R7 nonspec empty", 8'h00, 0, 1, 1, 1, 16'h8000);
    cycle("R6 ack src6", 8'h00, 1, 0, 0, 0, 16'h0);
    cycle("R6 ack empty", 8'h00, 1, 0, 0, 0, 16'h0);
    chk("R6 unchanged", 16'(inserv), 16'h0040);
    slave_mode = 1'b1;
    cycle("R9 high bits ignored", 8'h00, 0, 1, 1, 1, 16'hFFF6);
    chk("R9 level6 cleared", 16'(inserv), 16'h0000);
    cycle("R3 eoi read", 8'h00, 0, 1, 0, 1, 16'h0);

    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] r;
      logic [15:0] d;
      int op;
      if (n % 500 == 0) slave_mode = $urandom % 2;
      r  = m_req ^ N'($urandom & $urandom & $urandom);
      op = $urandom % 4;
      d  = 16'($urandom);
      d[4:0] = 5'($urandom % 20);
      cycle(slave_mode ? "R9/R10 rand" : "R2/R5/R6/R7/R8 rand", r,
            ($urandom % 3) == 0, op != 0, op >= 2, (op == 2) || (op == 1 && $urandom % 4 == 0), d);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule